// File: doc/BRIEF.md
# Alternating-Sign Recursive Input Restructurer

This block is the front end of a prime-length (N = 7 or N = 11) discrete cosine transform engine. It takes one real sample per accepted transfer, with the highest index first, and folds the samples into an auxiliary sequence xa. The running value is kept in one register. Each new sample is added to it or taken from it, and the choice depends on whether the sample index is even or odd. The first sample, x(N-1), is loaded into the register as it arrives.

The restructured values are kept in a small register file. When the sample with index 0 arrives, the block captures three things in its output register: xa(0), which later stages use directly as the DC coefficient; the sum of each fixed pair of xa values; and the difference of each such pair. These operands go to the convolution array, which is outside this block.

Both stream edges use valid/ready. An input transfer happens when `in_valid` and `in_ready` are both high on a clock edge. An output transfer happens when `out_valid` and `out_ready` are both high. A result stays on the outputs until it is taken. Samples with indices N-1 down to 1 are never stalled. The sample that completes a frame is stalled only while an earlier result is still waiting and is not being taken in that same cycle.

Top module: `altsign_restructurer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `out_valid` and `frame_done`, raises `in_ready`, and returns the sample index, so the next accepted sample is treated as x(N-1).
- R2: The first accepted sample of a frame is x(N-1), and xa(N-1) equals it sign-extended, without any sign change.
- R3: For i from N-2 down to 0, xa(i) = xa(i+1) + x(i) when i is even and xa(i+1) - x(i) when i is odd. Samples are signed two's complement of width W.
- R4: `out_xa0` carries xa(0) as a signed value of AW = W + ceil(log2 N) bits.
- R5: `out_sum` holds xa(a)+xa(b) for these (a,b) pairs, in this pair order k = 0,1,...: for N = 7, (6,1) (2,5) (3,4); for N = 11, (10,1) (2,9) (4,7) (8,3) (5,6).
- R6: `out_diff` holds xa(a)-xa(b) for the same pairs, in the same order.
- R7: Pair k occupies bits [k*OW +: OW] of `out_sum` and of `out_diff`, where OW = AW+1 and values are signed two's complement.
- R8: `frame_done` is high for exactly one cycle: the first cycle in which `out_valid` shows a newly completed frame.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and all result outputs keep their values.
- R10: `in_ready` is low exactly when the next sample to be accepted has index 0, `out_valid` is high and `out_ready` is low. A frame may complete in the same cycle as the previous result is taken.
- R11: No input pattern overflows the accumulation: the magnitude of xa(0) never exceeds N*2^(W-1).
- R12: A cycle with `in_valid` low changes neither the recursion nor the index, whatever value `in_sample` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_sample | input | W | Signed sample, highest index first |
| out_valid | output | 1 | Result registers hold a frame |
| out_ready | input | 1 | Downstream takes the result |
| out_xa0 | output | AW | xa(0), signed |
| out_sum | output | M*OW | Packed pair sums, M = (N-1)/2 |
| out_diff | output | M*OW | Packed pair differences |
| frame_done | output | 1 | One-cycle pulse when a frame completes |

## Verification
Two events can fall in the same cycle: the sample with index 0 completes a new frame, and the previous result is handed off. The bench makes this happen by holding `out_ready` low at random for long stretches, so whole frames arrive while a result is still waiting. It then raises `out_ready` in the very cycle the closing sample is offered. The outcome is judged from three things: `in_ready` must follow R10 in every cycle; the old result must be compared and retired at the handoff; and the new result must appear in the next cycle with a single `frame_done` pulse and values that match the bench's own model of the recursion.

// File: rtl/altsign_pkg.sv
package altsign_pkg;

  // Upper operand index of pair k (order is fixed by the convolution array)
  function automatic int pair_hi(input int n, input int k);
    int r;
    r = 0;
    if (n == 7) begin
      case (k)
        0: r = 6;
        1: r = 2;
        default: r = 3;
      endcase
    end else begin
      case (k)
        0: r = 10;
        1: r = 2;
        2: r = 4;
        3: r = 8;
        default: r = 5;
      endcase
    end
    return r;
  endfunction

  // Lower operand index of pair k
  function automatic int pair_lo(input int n, input int k);
    int r;
    r = 0;
    if (n == 7) begin
      case (k)
        0: r = 1;
        1: r = 5;
        default: r = 4;
      endcase
    end else begin
      case (k)
        0: r = 1;
        1: r = 9;
        2: r = 7;
        3: r = 3;
        default: r = 6;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/altsign_accum.sv
// Index counter, running register and parity-driven sign selection.
module altsign_accum #(
  parameter int W  = 8,
  parameter int N  = 7,
  parameter int IW = 3,
  parameter int AW = 11
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 take,
  input  logic [W-1:0]         sample,
  output logic [IW-1:0]        idx,
  output logic                 at_zero,
  output logic signed [AW-1:0] acc_next
);
  localparam logic [IW-1:0] TOP_IDX = IW'(N-1);

  logic signed [AW-1:0] acc_q;
  logic signed [AW-1:0] x_ext;
  logic                 first;
  logic                 odd;

  assign x_ext   = AW'($signed(sample));
  assign first   = (idx == TOP_IDX);
  assign odd     = idx[0];
  assign at_zero = (idx == '0);

  always_comb begin
    if (first)    acc_next = x_ext;
    else if (odd) acc_next = acc_q - x_ext;
    else          acc_next = acc_q + x_ext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx   <= TOP_IDX;
      acc_q <= '0;
    end else if (take) begin
      acc_q <= acc_next;
      idx   <= at_zero ? TOP_IDX : idx - 1'b1;
    end
  end
endmodule

// File: rtl/altsign_store.sv
// Holds xa(1)..xa(N-1) of the frame in progress; slot 0 reads as zero.
module altsign_store #(
  parameter int N  = 7,
  parameter int IW = 3,
  parameter int AW = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [IW-1:0]      widx,
  input  logic [AW-1:0]      wdata,
  output logic [N*AW-1:0]    xa_flat
);
  assign xa_flat[AW-1:0] = '0;

  for (genvar e = 1; e < N; e++) begin : g_slot
    logic [AW-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (rst)                           slot_q <= '0;
      else if (we && widx == IW'(e))     slot_q <= wdata;
    end
    assign xa_flat[e*AW +: AW] = slot_q;
  end
endmodule

// File: rtl/altsign_pairs.sv
// Sum and difference of each fixed xa pair.
module altsign_pairs
  import altsign_pkg::*;
#(
  parameter int N  = 7,
  parameter int AW = 11,
  parameter int OW = 12,
  parameter int M  = 3
) (
  input  logic [N*AW-1:0] xa_flat,
  output logic [M*OW-1:0] sum_flat,
  output logic [M*OW-1:0] diff_flat
);
  for (genvar k = 0; k < M; k++) begin : g_pair
    localparam int HI = pair_hi(N, k);
    localparam int LO = pair_lo(N, k);
    logic signed [OW-1:0] a_ext;
    logic signed [OW-1:0] b_ext;
    assign a_ext = OW'($signed(xa_flat[HI*AW +: AW]));
    assign b_ext = OW'($signed(xa_flat[LO*AW +: AW]));
    assign sum_flat[k*OW +: OW]  = a_ext + b_ext;
    assign diff_flat[k*OW +: OW] = a_ext - b_ext;
  end
endmodule

// File: rtl/altsign_restructurer.sv
module altsign_restructurer #(
  parameter  int W  = 8,
  parameter  int N  = 7,
  localparam int IW = $clog2(N),
  localparam int AW = W + IW,
  localparam int OW = AW + 1,
  localparam int M  = (N - 1) / 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [W-1:0]    in_sample,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [AW-1:0]   out_xa0,
  output logic [M*OW-1:0] out_sum,
  output logic [M*OW-1:0] out_diff,
  output logic            frame_done
);
  logic                 take;
  logic                 last_take;
  logic [IW-1:0]        idx;
  logic                 at_zero;
  logic signed [AW-1:0] acc_next;
  logic [N*AW-1:0]      xa_flat;
  logic [M*OW-1:0]      sum_c;
  logic [M*OW-1:0]      diff_c;

  // closing sample waits only while an untaken result occupies the outputs
  assign in_ready  = !(at_zero && out_valid && !out_ready);
  assign take      = in_valid && in_ready;
  assign last_take = take && at_zero;

  altsign_accum #(.W(W), .N(N), .IW(IW), .AW(AW)) u_accum (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .sample   (in_sample),
    .idx      (idx),
    .at_zero  (at_zero),
    .acc_next (acc_next)
  );

  altsign_store #(.N(N), .IW(IW), .AW(AW)) u_store (
    .clk     (clk),
    .rst     (rst),
    .we      (take && !at_zero),
    .widx    (idx),
    .wdata   (acc_next),
    .xa_flat (xa_flat)
  );

  altsign_pairs #(.N(N), .AW(AW), .OW(OW), .M(M)) u_pairs (
    .xa_flat   (xa_flat),
    .sum_flat  (sum_c),
    .diff_flat (diff_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      frame_done <= 1'b0;
      out_xa0    <= '0;
      out_sum    <= '0;
      out_diff   <= '0;
    end else begin
      frame_done <= last_take;
      if (last_take) begin
        out_valid <= 1'b1;
        out_xa0   <= acc_next;
        out_sum   <= sum_c;
        out_diff  <= diff_c;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/altsign_checker.sv
module altsign_checker #(
  parameter  int W  = 8,
  parameter  int N  = 7,
  localparam int IW = $clog2(N),
  localparam int AW = W + IW,
  localparam int OW = AW + 1,
  localparam int M  = (N - 1) / 2
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic [W-1:0]    in_sample,
  input logic            out_valid,
  input logic            out_ready,
  input logic [AW-1:0]   out_xa0,
  input logic [M*OW-1:0] out_sum,
  input logic [M*OW-1:0] out_diff,
  input logic            frame_done
);
  localparam int BOUND = N * (1 << (W - 1));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !out_valid && !frame_done);

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_xa0) &&
                                $stable(out_sum) && $stable(out_diff));

  // R10
  stall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> out_valid && !out_ready);

  // R8
  done_valid_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> out_valid);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($signed(out_xa0) <= BOUND) && ($signed(out_xa0) >= -BOUND));
endmodule

bind altsign_restructurer altsign_checker #(.W(W), .N(N)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_sample  (in_sample),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_xa0    (out_xa0),
  .out_sum    (out_sum),
  .out_diff   (out_diff),
  .frame_done (frame_done)
);

// File: tb/altsign_restructurer_bench.sv
`timescale 1ns/1ps
module altsign_restructurer_bench;
  localparam int W  = 8;
  localparam int N  = 7;
  localparam int IW = $clog2(N);
  localparam int AW = W + IW;
  localparam int OW = AW + 1;
  localparam int M  = (N - 1) / 2;
  localparam int NFRAMES = 80;

  logic            clk = 1'b0;
  logic            rst;
  logic            in_valid;
  logic            in_ready;
  logic [W-1:0]    in_sample;
  logic            out_valid;
  logic            out_ready;
  logic [AW-1:0]   out_xa0;
  logic [M*OW-1:0] out_sum;
  logic [M*OW-1:0] out_diff;
  logic            frame_done;

  always #2.5 clk = ~clk;

  altsign_restructurer #(.W(W), .N(N)) u_altsign_restructurer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .out_valid(out_valid), .out_ready(out_ready),
    .out_xa0(out_xa0), .out_sum(out_sum), .out_diff(out_diff),
    .frame_done(frame_done));

  int n_checks = 0;
  int n_fail   = 0;

  int smp [N];
  int pos;
  int frames_sent;
  int cycles;
  bit last_prev;
  bit hold_prev;
  bit stall_mode;
  logic [AW-1:0]   sv_xa0;
  logic [M*OW-1:0] sv_sum;
  logic [M*OW-1:0] sv_diff;

  logic [AW-1:0]   q_xa0  [$];
  logic [M*OW-1:0] q_sum  [$];
  logic [M*OW-1:0] q_diff [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int bhi(input int k);
    int t7 [3]  = '{6, 2, 3};
    int t11 [5] = '{10, 2, 4, 8, 5};
    return (N == 7) ? t7[k] : t11[k];
  endfunction

  function automatic int blo(input int k);
    int t7 [3]  = '{1, 5, 4};
    int t11 [5] = '{1, 9, 7, 3, 6};
    return (N == 7) ? t7[k] : t11[k];
  endfunction

  // Software model of the recursion; pushes the expected result
  task automatic push_expected();
    int xa [N];
    logic [M*OW-1:0] es;
    logic [M*OW-1:0] ed;
    xa[N-1] = smp[N-1];
    for (int i = N - 2; i >= 0; i--)
      xa[i] = xa[i+1] + (((i % 2) == 1) ? -smp[i] : smp[i]);
    for (int k = 0; k < M; k++) begin
      es[k*OW +: OW] = OW'(xa[bhi(k)] + xa[blo(k)]);
      ed[k*OW +: OW] = OW'(xa[bhi(k)] - xa[blo(k)]);
    end
    q_xa0.push_back(AW'(xa[0]));
    q_sum.push_back(es);
    q_diff.push_back(ed);
  endtask

  // Pattern per frame: directed extremes first, random afterwards
  task automatic new_frame(input int f);
    for (int i = 0; i < N; i++) begin
      case (f)
        0: smp[i] = 127;
        1: smp[i] = -128;
        2: smp[i] = (i % 2 == 0) ? 127 : -128;   // worst-case growth
        3: smp[i] = 0;
        4: smp[i] = (i == N - 1) ? -77 : 0;      // only x(N-1) present
        default: smp[i] = int'($urandom_range(255)) - 128;
      endcase
    end
  endtask

  // One cycle: check at negedge, drive, decide transfers
  task automatic step(input bit allow_in);
    int pr;
    bit in_fire;
    bit out_fire;
    @(negedge clk);
    cycles++;
    // R8: pulse exactly after the closing sample
    chk(frame_done == last_prev, "R8", "frame_done", 128'(frame_done), 128'(last_prev));
    if (hold_prev) begin
      // R9
      chk(out_valid && out_xa0 == sv_xa0 && out_sum == sv_sum && out_diff == sv_diff,
          "R9", "held result", 128'(out_sum), 128'(sv_sum));
    end
    if ($urandom_range(39) == 0) stall_mode = !stall_mode;
    pr = stall_mode ? 10 : 75;
    out_ready = ($urandom_range(99) < pr);
    in_valid  = allow_in && ($urandom_range(99) < 80);
    if (in_valid) in_sample = W'(smp[N-1-pos]);
    else          in_sample = W'($urandom);      // R12: garbage while idle
    #1;
    // R10
    chk(in_ready == !(pos == N - 1 && out_valid && !out_ready), "R10", "in_ready",
        128'(in_ready), 128'(!(pos == N - 1 && out_valid && !out_ready)));
    in_fire  = in_valid && in_ready;
    out_fire = out_valid && out_ready;
    if (out_fire) begin
      if (q_xa0.size() == 0) begin
        chk(1'b0, "R8", "unexpected result", 128'(out_xa0), 128'(0));
      end else begin
        // R2 R3 R4 R12
        chk(out_xa0 == q_xa0[0], "R3 R4 R12", "xa0", 128'(out_xa0), 128'(q_xa0[0]));
        // R2 R5 R7
        chk(out_sum == q_sum[0], "R2 R5 R7", "sums", 128'(out_sum), 128'(q_sum[0]));
        // R6 R7
        chk(out_diff == q_diff[0], "R6 R7", "diffs", 128'(out_diff), 128'(q_diff[0]));
        // R11
        chk($signed(out_xa0) <= N * 128 && $signed(out_xa0) >= -N * 128,
            "R11", "xa0 range", 128'(out_xa0), 128'(N * 128));
        void'(q_xa0.pop_front());
        void'(q_sum.pop_front());
        void'(q_diff.pop_front());
      end
    end
    last_prev = 1'b0;
    if (in_fire) begin
      pos++;
      if (pos == N) begin
        push_expected();
        pos = 0;
        last_prev = 1'b1;
        frames_sent++;
        new_frame(frames_sent);
      end
    end
    hold_prev = out_valid && !out_ready;
    sv_xa0 = out_xa0; sv_sum = out_sum; sv_diff = out_diff;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    pos = 0; last_prev = 1'b0; hold_prev = 1'b0;
    q_xa0.delete(); q_sum.delete(); q_diff.delete();
    #1;
    // R1
    chk(!out_valid, "R1", "out_valid", 128'(out_valid), 128'(0));
    chk(!frame_done, "R1", "frame_done", 128'(frame_done), 128'(0));
    chk(in_ready, "R1", "in_ready", 128'(in_ready), 128'(1));
  endtask

  initial begin
    void'($urandom(32'd24681));
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0; in_sample = '0;
    cycles = 0; frames_sent = 0; stall_mode = 1'b0;
    do_reset();
    // R1: abandon a partial frame with a reset, then a full frame must be clean
    new_frame(99);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sample = W'(smp[N-1-c]);
    end
    do_reset();
    frames_sent = 0;
    new_frame(0);
    while ((frames_sent < NFRAMES || q_xa0.size() != 0) && cycles < 100000)
      step(frames_sent < NFRAMES);
    if (cycles >= 100000)
      chk(1'b0, "R10", "watchdog expired", 128'(cycles), 128'(0));
    chk(frames_sent == NFRAMES, "R8", "frames completed", 128'(frames_sent), 128'(NFRAMES));
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule